// File: doc/BRIEF.md
# Link-Side Receive Decoder for a Serial-Bus Physical Layer

This block sits on the link side of the interface to a serial-bus physical layer. It watches a 2-bit control bus and an 8-bit data bus. Both are sampled on the system clock. When the control bus shows receive (binary 10), a receive operation begins. This holds whether the bus was idle or was in the middle of a status transfer.

Any leading data-on cycles are skipped. The first non-data-on cycle is taken as the speed code. That code sets how many data bits each later cycle carries:

| Speed | Bits per cycle | Source bits |
|-------|----------------|-------------|
| Lowest rate (S100) | 2 | `dat_i[7:6]` |
| Middle rate (S200) | 4 | `dat_i[7:4]` |
| Highest rate (S400) | 8 | `dat_i` |

The block assembles whole bytes from these bits and delivers them on a byte stream. The stream has a valid strobe, a first-byte marker and a last-byte marker. Events are reported on one-cycle strobes:

- a null packet,
- an unusable speed code,
- a byte cut short at the end of a packet,
- a receive operation closed by a non-idle control value.

The controller is a four-state machine:

- **IDLE**: no receive operation is in progress.
- **PREAMBLE**: receive is asserted and only data-on has been seen so far.
- **PAYLOAD**: the speed code was accepted and data is being packed.
- **DISCARD**: the speed code was rejected and data is being ignored.

The transitions are:

| Name | From | To | Condition |
|------|------|----|-----------|
| *start-preamble* | IDLE | PREAMBLE | receive with data-on |
| *accept* | IDLE or PREAMBLE | PAYLOAD | receive, not data-on, usable code |
| *reject* | IDLE or PREAMBLE | DISCARD | receive, not data-on, unusable code |
| *null-end* | PREAMBLE | IDLE | control leaves receive |
| *payload-end* | PAYLOAD | IDLE | control leaves receive |
| *discard-end* | DISCARD | IDLE | control leaves receive |

In all other cases the state holds.

Top module: `rx_link_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, every strobe output is 0 and `speed_o` is 0 until a receive operation starts.
- R2: A receive operation starts on any cycle with `ctl_i`=10 while the machine is in IDLE, whatever the previous control value was, including 01 (status). Cycles with `dat_i[7]`=1 are data-on and are skipped. There may be zero or more of them.
- R3: The first non-data-on receive cycle is the speed code. `dat_i[7:6]`=00 gives S100 and `speed_o`=0. `dat_i[7:4]`=0100 gives S200 and `speed_o`=1. `dat_i`=8'h50 gives S400 and `speed_o`=2. `speed_o` changes one clock after an accepted code and holds until the next accepted code.
- R4: The speed-code cycle contributes no bits to the packet data.
- R5: Each later receive cycle adds the bits listed for its speed (2, 4 or 8 bits, as in the table above). Bits are placed most-significant first into each byte.
- R6: Each completed byte is held back by one byte slot. It is output with `rx_valid_o` on the clock at which the next byte completes. The final byte is output on the clock at which `ctl_i` leaves 10, with `rx_last_o`=1. `rx_first_o` marks the first byte of a packet.
- R7: A speed code that matches none of the three patterns, or names a speed above `MAX_SPEED`, pulses `speed_err_o` one clock after the code. No bytes are output until the operation ends.
- R8: An operation with only data-on cycles pulses `null_pkt_o` on the clock at which `ctl_i` leaves 10. No bytes are output.
- R9: If `ctl_i` leaves 10 with a partly filled byte, `trunc_err_o` pulses on that clock and the partial bits are dropped. Any held complete byte is still output with `rx_last_o` on the same clock.
- R10: If `ctl_i` leaves 10 for 01 or 11 instead of 00, the operation ends exactly as on idle and `proto_err_o` pulses. A receive operation may start on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 2 | Control bus: 00 idle, 01 status, 10 receive, 11 transmit |
| dat_i | input | 8 | Data bus; bit 7 is the first lane bit |
| rx_byte_o | output | 8 | Assembled byte |
| rx_valid_o | output | 1 | `rx_byte_o` valid this cycle |
| rx_first_o | output | 1 | First byte of packet |
| rx_last_o | output | 1 | Last byte of packet |
| speed_o | output | 2 | Decoded speed of current packet |
| null_pkt_o | output | 1 | Null packet strobe |
| speed_err_o | output | 1 | Unusable speed code strobe |
| trunc_err_o | output | 1 | Partial byte dropped strobe |
| proto_err_o | output | 1 | Receive closed by non-idle control strobe |

## Verification
The flush of the held final byte can fall in the same clock as the truncation report. In that clock the output stage emits a complete byte with its last marker, while the packer drops the leftover bits. The bench provokes this with an S200 packet of three data cycles, which leaves half a byte. At the idle edge it expects the held byte with both the first and the last marker set, together with `trunc_err_o`.

A second coincidence comes from ending a packet with status instead of idle: the last byte and `proto_err_o` appear together. A new receive follows on the next cycle, and its speed and bytes must come out clean.

// File: rtl/rxdec_pkg.sv
`timescale 1ns/1ps
package rxdec_pkg;
    localparam int BUS_W  = 8;
    localparam int BYTE_W = 8;
    localparam int FILL_W = $clog2(BYTE_W + 1);

    localparam logic [1:0] CTL_IDLE   = 2'b00;
    localparam logic [1:0] CTL_STATUS = 2'b01;
    localparam logic [1:0] CTL_RECV   = 2'b10;
    localparam logic [1:0] CTL_XMIT   = 2'b11;

    typedef enum logic [1:0] {
        SPD_S100 = 2'd0,
        SPD_S200 = 2'd1,
        SPD_S400 = 2'd2,
        SPD_BAD  = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_PAYLOAD,
        ST_DISCARD
    } rx_state_e;
endpackage

// File: rtl/rxdec_speed_classify.sv
`timescale 1ns/1ps
module rxdec_speed_classify
    import rxdec_pkg::*;
(
    input  logic [BUS_W-1:0] dat_i,
    output logic             dataon_o,
    output speed_e           code_o
);
    always_comb begin
        dataon_o = dat_i[BUS_W-1];
        if (dat_i[BUS_W-1 -: 2] == 2'b00)
            code_o = SPD_S100;
        else if (dat_i[BUS_W-1 -: 4] == 4'b0100)
            code_o = SPD_S200;
        else if (dat_i == 8'h50)
            code_o = SPD_S400;
        else
            code_o = SPD_BAD;
    end
endmodule

// File: rtl/rxdec_lane_packer.sv
`timescale 1ns/1ps
module rxdec_lane_packer
    import rxdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  speed_e            speed_i,
    input  logic [BUS_W-1:0]  dat_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              partial_o
);
    logic [BYTE_W-1:0] acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] step;
    logic [FILL_W-1:0] fill_nxt;

    always_comb begin
        unique case (speed_i)
            SPD_S100: begin
                byte_o = {acc_q[BYTE_W-3:0], dat_i[BUS_W-1 -: 2]};
                step   = FILL_W'(2);
            end
            SPD_S200: begin
                byte_o = {acc_q[BYTE_W-5:0], dat_i[BUS_W-1 -: 4]};
                step   = FILL_W'(4);
            end
            default: begin
                byte_o = dat_i;
                step   = FILL_W'(BYTE_W);
            end
        endcase
        fill_nxt  = fill_q + step;
        done_o    = shift_i && (fill_nxt == FILL_W'(BYTE_W));
        partial_o = (fill_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (shift_i) begin
            acc_q  <= byte_o;
            fill_q <= done_o ? '0 : fill_nxt;
        end
    end
endmodule

// File: rtl/rxdec_ctrl.sv
`timescale 1ns/1ps
module rxdec_ctrl
    import rxdec_pkg::*;
#(
    parameter int MAX_SPEED = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_i,
    input  logic       dataon_i,
    input  speed_e     code_i,
    output logic       capture_o,
    output logic       shift_o,
    output logic       flush_o,
    output logic       null_evt_o,
    output logic       spderr_evt_o,
    output logic       proto_evt_o
);
    rx_state_e state_q, state_d;
    logic recv, code_ok, decoding;

    assign recv     = (ctl_i == CTL_RECV);
    assign code_ok  = (code_i != SPD_BAD) && (int'(code_i) <= MAX_SPEED);
    assign decoding = (state_q == ST_IDLE) || (state_q == ST_PREAMBLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PREAMBLE: begin
                if (recv) begin
                    if (dataon_i)     state_d = ST_PREAMBLE;
                    else if (code_ok) state_d = ST_PAYLOAD;
                    else              state_d = ST_DISCARD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_PAYLOAD, ST_DISCARD: begin
                if (!recv) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o    = decoding && recv && !dataon_i && code_ok;
        spderr_evt_o = decoding && recv && !dataon_i && !code_ok;
        shift_o      = (state_q == ST_PAYLOAD) && recv;
        flush_o      = (state_q == ST_PAYLOAD) && !recv;
        null_evt_o   = (state_q == ST_PREAMBLE) && !recv;
        proto_evt_o  = (state_q != ST_IDLE) && !recv && (ctl_i != CTL_IDLE);
    end
endmodule

// File: rtl/rxdec_out_stage.sv
`timescale 1ns/1ps
module rxdec_out_stage
    import rxdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] push_byte_i,
    input  logic              flush_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              first_o,
    output logic              last_o
);
    logic [BYTE_W-1:0] hold_b;
    logic              hold_v, hold_f, first_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_b     <= '0;
            hold_v     <= 1'b0;
            hold_f     <= 1'b0;
            first_pend <= 1'b0;
            byte_o     <= '0;
            valid_o    <= 1'b0;
            first_o    <= 1'b0;
            last_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            first_o <= 1'b0;
            last_o  <= 1'b0;
            if (clear_i) begin
                hold_v     <= 1'b0;
                first_pend <= 1'b1;
            end else if (push_i) begin
                if (hold_v) begin
                    byte_o  <= hold_b;
                    valid_o <= 1'b1;
                    first_o <= hold_f;
                end
                hold_b     <= push_byte_i;
                hold_f     <= first_pend;
                first_pend <= 1'b0;
                hold_v     <= 1'b1;
            end else if (flush_i) begin
                if (hold_v) begin
                    byte_o  <= hold_b;
                    valid_o <= 1'b1;
                    first_o <= hold_f;
                    last_o  <= 1'b1;
                end
                hold_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_link_decoder.sv
`timescale 1ns/1ps
module rx_link_decoder
    import rxdec_pkg::*;
#(
    parameter int MAX_SPEED = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_i,
    input  logic [7:0] dat_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       rx_first_o,
    output logic       rx_last_o,
    output logic [1:0] speed_o,
    output logic       null_pkt_o,
    output logic       speed_err_o,
    output logic       trunc_err_o,
    output logic       proto_err_o
);
    logic              dataon, capture, shift, flush;
    logic              null_evt, spderr_evt, proto_evt;
    logic              done, partial;
    logic [BYTE_W-1:0] packed_byte;
    speed_e            code, cur_speed;

    rxdec_speed_classify u_cls (
        .dat_i    (dat_i),
        .dataon_o (dataon),
        .code_o   (code)
    );

    rxdec_ctrl #(.MAX_SPEED(MAX_SPEED)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_i        (ctl_i),
        .dataon_i     (dataon),
        .code_i       (code),
        .capture_o    (capture),
        .shift_o      (shift),
        .flush_o      (flush),
        .null_evt_o   (null_evt),
        .spderr_evt_o (spderr_evt),
        .proto_evt_o  (proto_evt)
    );

    rxdec_lane_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (capture),
        .shift_i   (shift),
        .speed_i   (cur_speed),
        .dat_i     (dat_i),
        .done_o    (done),
        .byte_o    (packed_byte),
        .partial_o (partial)
    );

    rxdec_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (capture),
        .push_i      (done),
        .push_byte_i (packed_byte),
        .flush_i     (flush),
        .byte_o      (rx_byte_o),
        .valid_o     (rx_valid_o),
        .first_o     (rx_first_o),
        .last_o      (rx_last_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_speed   <= SPD_S100;
            null_pkt_o  <= 1'b0;
            speed_err_o <= 1'b0;
            trunc_err_o <= 1'b0;
            proto_err_o <= 1'b0;
        end else begin
            if (capture) cur_speed <= code;
            null_pkt_o  <= null_evt;
            speed_err_o <= spderr_evt;
            trunc_err_o <= flush && partial;
            proto_err_o <= proto_evt;
        end
    end

    assign speed_o = cur_speed;
endmodule

// File: rtl/rxdec_checker.sv
`timescale 1ns/1ps
module rxdec_checker
    import rxdec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ctl_i,
    input logic       rx_valid_o,
    input logic       rx_first_o,
    input logic       rx_last_o,
    input logic [1:0] speed_o,
    input logic       null_pkt_o,
    input logic       speed_err_o,
    input logic       trunc_err_o,
    input logic       proto_err_o
);
    assert_first_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first_o |-> rx_valid_o);

    assert_last_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last_o |-> (rx_valid_o && $past(ctl_i) != CTL_RECV));

    assert_null_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        null_pkt_o |-> (!rx_valid_o && $past(ctl_i) != CTL_RECV));

    assert_spderr_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        speed_err_o |-> (!rx_valid_o && $past(ctl_i) == CTL_RECV));

    assert_trunc_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_err_o |-> ($past(ctl_i) != CTL_RECV));

    assert_proto_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> ($past(ctl_i) == CTL_STATUS || $past(ctl_i) == CTL_XMIT));

    assert_speed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !rx_first_o) |-> $stable(speed_o));
endmodule

bind rx_link_decoder rxdec_checker u_chk (.*);

// File: tb/tb_rx_link_decoder.sv
`timescale 1ns/1ps
module tb_rx_link_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ctl = 2'b00;
    logic [7:0] dat = 8'h00;

    logic [7:0] byte_a, byte_b;
    logic       val_a, fst_a, lst_a, null_a, serr_a, trn_a, prt_a;
    logic       val_b, fst_b, lst_b, null_b, serr_b, trn_b, prt_b;
    logic [1:0] spd_a, spd_b;

    int checks = 0;
    int fails  = 0;
    int cnt_a  = 0;
    int cnt_b  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_link_decoder #(.MAX_SPEED(2)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .dat_i(dat),
        .rx_byte_o(byte_a), .rx_valid_o(val_a), .rx_first_o(fst_a), .rx_last_o(lst_a),
        .speed_o(spd_a), .null_pkt_o(null_a), .speed_err_o(serr_a),
        .trunc_err_o(trn_a), .proto_err_o(prt_a)
    );

    rx_link_decoder #(.MAX_SPEED(1)) dut_lim (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .dat_i(dat),
        .rx_byte_o(byte_b), .rx_valid_o(val_b), .rx_first_o(fst_b), .rx_last_o(lst_b),
        .speed_o(spd_b), .null_pkt_o(null_b), .speed_err_o(serr_b),
        .trunc_err_o(trn_b), .proto_err_o(prt_b)
    );

    // {ctl, dat, valid/first/last expected, byte expected}
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {2'b01, 8'h00, 3'b000, 8'h00},
        {2'b10, 8'hFF, 3'b000, 8'h00},
        {2'b10, 8'h80, 3'b000, 8'h00},
        {2'b10, 8'h50, 3'b000, 8'h00},
        {2'b10, 8'hA1, 3'b000, 8'h00},
        {2'b10, 8'hB2, 3'b110, 8'hA1},
        {2'b10, 8'hC3, 3'b100, 8'hB2},
        {2'b00, 8'h00, 3'b101, 8'hC3},
        {2'b00, 8'h00, 3'b000, 8'h00},
        {2'b10, 8'h4F, 3'b000, 8'h00},
        {2'b10, 8'hD0, 3'b000, 8'h00},
        {2'b10, 8'h70, 3'b000, 8'h00},
        {2'b10, 8'h30, 3'b000, 8'h00},
        {2'b10, 8'hC5, 3'b110, 8'hD7},
        {2'b00, 8'h00, 3'b101, 8'h3C},
        {2'b10, 8'h3F, 3'b000, 8'h00},
        {2'b10, 8'h40, 3'b000, 8'h00},
        {2'b10, 8'hC0, 3'b000, 8'h00},
        {2'b10, 8'h00, 3'b000, 8'h00},
        {2'b10, 8'h80, 3'b000, 8'h00},
        {2'b00, 8'h00, 3'b111, 8'h72},
        {2'b00, 8'h00, 3'b000, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        ctl = c;
        dat = d;
        @(posedge clk);
        #1;
        if (val_a) cnt_a++;
        if (val_b) cnt_b++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) step(2'b10, 8'h50);
        chk("R1 valid in reset", {31'd0, val_a}, 0);
        chk("R1 speed in reset", {30'd0, spd_a}, 0);
        chk("R1 strobes in reset", {28'd0, null_a, serr_a, trn_a, prt_a}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 8'h00);
        chk("R1 after release", {27'd0, val_a, fst_a, lst_a, null_a, serr_a}, 0);

        // Table walk: R2 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20:19], VEC[i][18:11]);
            chk($sformatf("R2 R4 R5 R6 vec%0d flags", i),
                {29'd0, val_a, fst_a, lst_a}, {29'd0, VEC[i][10:8]});
            if (VEC[i][10])
                chk($sformatf("R5 vec%0d byte", i), {24'd0, byte_a}, {24'd0, VEC[i][7:0]});
        end
        chk("R3 S100 held after packet", {30'd0, spd_a}, 0);

        // R3 S400 speed and hold
        step(2'b10, 8'h50);
        chk("R3 S400 decoded", {30'd0, spd_a}, 2);
        step(2'b10, 8'hAA);
        step(2'b10, 8'h55);
        chk("R6 first S400 byte", {23'd0, val_a, byte_a}, {23'd0, 1'b1, 8'hAA});
        step(2'b00, 8'h00);
        chk("R6 last S400 byte", {22'd0, val_a, lst_a, byte_a}, {22'd0, 2'b11, 8'h55});
        step(2'b00, 8'h00);
        chk("R3 S400 held", {30'd0, spd_a}, 2);

        // R9 truncation coinciding with last byte
        step(2'b10, 8'h4A);
        chk("R3 S200 decoded", {30'd0, spd_a}, 1);
        step(2'b10, 8'hA0);
        step(2'b10, 8'hB0);
        step(2'b10, 8'hC0);
        chk("R9 no byte before end", {31'd0, val_a}, 0);
        step(2'b00, 8'h00);
        chk("R9 held byte flushed", {20'd0, val_a, fst_a, lst_a, trn_a, byte_a},
            {20'd0, 4'b1111, 8'hAB});
        step(2'b00, 8'h00);
        chk("R9 trunc one pulse", {30'd0, trn_a, val_a}, 0);

        // R7 invalid codes
        cnt_a = 0;
        step(2'b10, 8'h60);
        chk("R7 invalid 0x60 flagged", {31'd0, serr_a}, 1);
        chk("R7 speed unchanged", {30'd0, spd_a}, 1);
        step(2'b10, 8'h11);
        step(2'b10, 8'h22);
        step(2'b10, 8'h33);
        step(2'b00, 8'h00);
        step(2'b10, 8'hFF);
        step(2'b10, 8'h51);
        chk("R7 invalid 0x51 flagged", {31'd0, serr_a}, 1);
        step(2'b10, 8'hAB);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R7 no bytes from discarded", cnt_a, 0);

        // R7 above configured maximum
        cnt_a = 0;
        cnt_b = 0;
        step(2'b10, 8'h50);
        chk("R7 S400 accepted at max 2", {31'd0, serr_a}, 0);
        chk("R7 S400 rejected at max 1", {31'd0, serr_b}, 1);
        step(2'b10, 8'h77);
        step(2'b10, 8'h88);
        step(2'b00, 8'h00);
        step(2'b00, 8'h00);
        chk("R7 limited block emits nothing", cnt_b, 0);
        chk("R7 full block emits two", cnt_a, 2);

        // R8 null packet
        cnt_a = 0;
        step(2'b10, 8'hFF);
        step(2'b10, 8'hC3);
        step(2'b00, 8'h00);
        chk("R8 null reported", {31'd0, null_a}, 1);
        step(2'b00, 8'h00);
        chk("R8 null one pulse", {31'd0, null_a}, 0);
        chk("R8 null no bytes", cnt_a, 0);

        // R10 non-idle end then immediate restart; R2 start from status
        step(2'b01, 8'h00);
        step(2'b10, 8'h50);
        chk("R2 start from status", {30'd0, spd_a}, 2);
        step(2'b10, 8'h11);
        step(2'b01, 8'h00);
        chk("R10 proto with last byte", {20'd0, val_a, fst_a, lst_a, prt_a, byte_a},
            {20'd0, 4'b1111, 8'h11});
        step(2'b10, 8'h4E);
        chk("R10 restart decoded", {30'd0, prt_a, spd_a[1]}, 0);
        step(2'b10, 8'h20);
        step(2'b10, 8'h20);
        step(2'b00, 8'h00);
        chk("R10 restart byte", {21'd0, val_a, fst_a, lst_a, byte_a},
            {21'd0, 3'b111, 8'h22});
        step(2'b00, 8'h00);

        finish_run();
    end
endmodule